// File: doc/BRIEF.md
# Latch-Off Fault Qualifier

This block decides when a switching power controller must shut itself down for good. It watches two comparator outputs that are already digital. One reports that an external protection pin sits above its trip level. The other reports that the supply rail sits above its overvoltage level. It also watches the gate-drive command, a one-clock strobe that marks the start of each switching cycle, and a power-on reset. Once it decides to shut down, it holds a sticky latch that forces the gate drive low on the same clock edge.

The protection pin is only looked at during the off-time of each switching cycle, and only after a blanking interval that follows the gate turn-off edge. Within that window the comparator must stay high for a minimum number of clocks to count as an event for that cycle. The latch fires on the qualifying event of the fourth switching cycle in a row that has one. The supply path ignores switching cycles. Its comparator only has to stay high without a break for a persistence time.

The latch never clears because a fault goes away. It clears only when the hold-current sense reports that the supply has really collapsed, or on power-on reset. All delays are counted in system-clock ticks. The defaults assume a 50 MHz clock: 1 µs of blanking, 600 ns minimum width and 20 µs persistence.

Top module: `latchoff_qualifier`

## Requirements
- R1: After `rst` (synchronous, active high), `latched` is 0, `gate_out` is 0, and the event count, the window state and the persistence count are all cleared.
- R2: `gate_out` is `gate_in` registered by one clock while the block is not latched. It is 0 from the same edge at which the latch fires, and it stays 0 while latched.
- R3: A turn-off is a clock edge at which `gate_in` is sampled 0 after being sampled 1 at the previous edge. The protection comparator is ignored at that edge and at the next `BLANK_TICKS` edges.
- R4: After blanking, the comparator counts as an event only if it is sampled high at `MINW_TICKS` consecutive edges. A run of highs that is broken earlier counts for nothing, and the next run starts from zero.
- R5: The latch fires at the edge where the qualifying event of the `EVENT_COUNT`-th consecutive switching cycle completes.
- R6: If `cycle_tick` arrives and no event qualified since the previous `cycle_tick`, the consecutive-cycle count returns to zero.
- R7: Comparator highs between a `cycle_tick` and the following turn-off, or at the `cycle_tick` edge itself, are ignored. At most one event counts per switching cycle.
- R8: `rail_ov` fires the latch when it is sampled high at `OVP_TICKS` consecutive edges. Any edge where it is sampled low restarts the persistence count from zero.
- R9: Once set, `latched` stays 1 whatever the fault inputs, `gate_in` or `cycle_tick` do.
- R10: `hold_lost` sampled high clears `latched` at that edge. It also clears the event count, the window state and the persistence count, and it wins over a fault that fires at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| hold_lost | input | 1 | High when the latch hold current is gone (supply cycled) |
| cycle_tick | input | 1 | One-clock strobe at the start of each switching cycle |
| gate_in | input | 1 | Gate-drive command from the modulator |
| prot_cmp | input | 1 | Protection pin comparator, high above the trip level |
| rail_ov | input | 1 | Supply overvoltage comparator, high above the trip level |
| gate_out | output | 1 | Registered gate drive, forced low while latched |
| latched | output | 1 | Sticky latch-off state |

## Verification
For a pin event, the latch and `gate_out` change at the edge that samples the `MINW_TICKS`-th consecutive qualifying high. The earliest sample that can count is the one `BLANK_TICKS + 1` edges after the turn-off edge. For the supply path, they change at the `OVP_TICKS`-th consecutive high sample. The bench drives every input on the falling clock edge and builds each switching cycle from fixed positions, so it knows which rising edge samples each position. It reads the outputs one falling edge after the last stimulus position, which covers a latch that fires at the final edge of a cycle. Its expected result for each pulse start and width comes from the blank length, the minimum width and the window bounds, not from the design.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Counter width able to hold values 0..n inclusive.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lq_pin_window.sv
module lq_pin_window
  import lq_pkg::*;
#(
  parameter int BLANK_TICKS = 50,
  parameter int MINW_TICKS  = 30
) (
  input  logic clk,
  input  logic clr,
  input  logic gate_fall,
  input  logic cycle_tick,
  input  logic cmp,
  output logic evt
);
  localparam int BW = cnt_width(BLANK_TICKS);
  localparam int MW = cnt_width(MINW_TICKS);

  logic          open_q;
  logic          done_q;
  logic [BW-1:0] blank_q;
  logic [MW-1:0] width_q;
  logic          sampling;

  // Comparator is looked at only inside an open, unblanked window that
  // has not yet produced its event, and never on a turn-off or tick edge.
  assign sampling = open_q && (blank_q == '0) && !done_q && !gate_fall && !cycle_tick;
  assign evt      = sampling && cmp && (width_q == MW'(MINW_TICKS - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      blank_q <= '0;
      width_q <= '0;
    end else if (gate_fall) begin
      open_q  <= 1'b1;
      done_q  <= 1'b0;
      blank_q <= BW'(BLANK_TICKS);
      width_q <= '0;
    end else if (cycle_tick) begin
      open_q  <= 1'b0;
      width_q <= '0;
    end else if (open_q) begin
      if (blank_q != '0) begin
        blank_q <= blank_q - BW'(1);
      end else if (evt) begin
        done_q  <= 1'b1;
        width_q <= '0;
      end else if (sampling && cmp) begin
        width_q <= width_q + MW'(1);
      end else begin
        width_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lq_run_counter.sv
module lq_run_counter
  import lq_pkg::*;
#(
  parameter int EVENT_COUNT = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic evt,
  input  logic cycle_tick,
  output logic fire
);
  localparam int EW = cnt_width(EVENT_COUNT);

  logic [EW-1:0] run_q;
  logic          seen_q;

  assign fire = evt && (run_q == EW'(EVENT_COUNT - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (evt) begin
        if (!fire) run_q <= run_q + EW'(1);
      end else if (cycle_tick && !seen_q) begin
        run_q <= '0;
      end

      if (cycle_tick)  seen_q <= 1'b0;
      else if (evt)    seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lq_persist.sv
module lq_persist
  import lq_pkg::*;
#(
  parameter int OVP_TICKS = 1000
) (
  input  logic clk,
  input  logic clr,
  input  logic cond,
  output logic fire
);
  localparam int PW = cnt_width(OVP_TICKS);

  logic [PW-1:0] hold_q;

  assign fire = cond && (hold_q == PW'(OVP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (clr || !cond) hold_q <= '0;
    else if (!fire)   hold_q <= hold_q + PW'(1);
  end
endmodule

// File: rtl/latchoff_qualifier.sv
module latchoff_qualifier #(
  parameter int BLANK_TICKS = 50,
  parameter int MINW_TICKS  = 30,
  parameter int EVENT_COUNT = 4,
  parameter int OVP_TICKS   = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_lost,
  input  logic cycle_tick,
  input  logic gate_in,
  input  logic prot_cmp,
  input  logic rail_ov,
  output logic gate_out,
  output logic latched
);
  logic gate_q;
  logic gate_fall;
  logic clr;
  logic pin_evt;
  logic pin_fire;
  logic rail_fire;
  logic latch_nxt;

  assign clr       = rst || hold_lost;
  assign gate_fall = gate_q && !gate_in;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_in;
  end

  lq_pin_window #(
    .BLANK_TICKS(BLANK_TICKS),
    .MINW_TICKS (MINW_TICKS)
  ) u_window (
    .clk       (clk),
    .clr       (clr),
    .gate_fall (gate_fall),
    .cycle_tick(cycle_tick),
    .cmp       (prot_cmp),
    .evt       (pin_evt)
  );

  lq_run_counter #(
    .EVENT_COUNT(EVENT_COUNT)
  ) u_run (
    .clk       (clk),
    .clr       (clr),
    .evt       (pin_evt),
    .cycle_tick(cycle_tick),
    .fire      (pin_fire)
  );

  lq_persist #(
    .OVP_TICKS(OVP_TICKS)
  ) u_rail (
    .clk (clk),
    .clr (clr),
    .cond(rail_ov),
    .fire(rail_fire)
  );

  // Release has priority: a collapsed supply cannot hold the latch.
  assign latch_nxt = hold_lost ? 1'b0 : (latched || pin_fire || rail_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      latched  <= 1'b0;
      gate_out <= 1'b0;
    end else begin
      latched  <= latch_nxt;
      gate_out <= gate_in && !latch_nxt;
    end
  end
endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
  parameter int OVP_TICKS = 1000
) (
  input logic clk,
  input logic rst,
  input logic hold_lost,
  input logic rail_ov,
  input logic gate_out,
  input logic latched
);
  localparam int RW = lq_pkg::cnt_width(OVP_TICKS);

  logic [RW-1:0] rail_run;

  always_ff @(posedge clk) begin
    if (rst || hold_lost || !rail_ov) rail_run <= '0;
    else if (rail_run != RW'(OVP_TICKS)) rail_run <= rail_run + RW'(1);
  end

  // R2: no drive while latched
  a_r2_gate_off: assert property (@(posedge clk) disable iff (rst)
    latched |-> !gate_out);

  // R9: latch holds unless released
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (latched && !hold_lost) |=> latched);

  // R10: release clears the latch
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    hold_lost |=> !latched);

  // R8: persistence window reached fires the latch
  a_r8_rail_fire: assert property (@(posedge clk) disable iff (rst)
    (rail_ov && !hold_lost && rail_run >= RW'(OVP_TICKS - 1)) |=> latched);
endmodule

bind latchoff_qualifier lq_checker #(.OVP_TICKS(OVP_TICKS)) u_lq_chk (
  .clk      (clk),
  .rst      (rst),
  .hold_lost(hold_lost),
  .rail_ov  (rail_ov),
  .gate_out (gate_out),
  .latched  (latched)
);

// File: tb/latchoff_qualifier_test.sv
module latchoff_qualifier_test;
  localparam int B   = 4;
  localparam int M   = 3;
  localparam int N   = 4;
  localparam int OVP = 10;
  localparam int PER = 30;
  localparam int ON_LAST   = 10;               // gate high at positions 1..10
  localparam int FIRST_SMP = ON_LAST + 1 + B + 1; // first position that can count
  localparam int LAST_POS  = PER - 1;

  logic clk = 1'b0;
  logic rst, hold_lost, cycle_tick, gate_in, prot_cmp, rail_ov;
  logic gate_out, latched;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  latchoff_qualifier #(
    .BLANK_TICKS(B), .MINW_TICKS(M), .EVENT_COUNT(N), .OVP_TICKS(OVP)
  ) uut (
    .clk(clk), .rst(rst), .hold_lost(hold_lost), .cycle_tick(cycle_tick),
    .gate_in(gate_in), .prot_cmp(prot_cmp), .rail_ov(rail_ov),
    .gate_out(gate_out), .latched(latched)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // One switching cycle; protection high at positions [s, s+w).
  task automatic run_cycle(input int s, input int w);
    for (int p = 0; p < PER; p++) begin
      cycle_tick = (p == 0);
      gate_in    = (p >= 1 && p <= ON_LAST);
      prot_cmp   = (p >= s && p < s + w);
      @(negedge clk);
    end
    cycle_tick = 1'b0;
    prot_cmp   = 1'b0;
  endtask

  task automatic release_latch();
    hold_lost = 1'b1;
    @(negedge clk);
    hold_lost = 1'b0;
    @(negedge clk);
  endtask

  task automatic rail_hold(input int n);
    rail_ov = 1'b1;
    repeat (n) @(negedge clk);
    rail_ov = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit qualifies(input int s, input int w);
    int st = (s < FIRST_SMP) ? FIRST_SMP : s;
    return (s + w - st >= M) && (st + M - 1 <= LAST_POS);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hold_lost = 1'b0; cycle_tick = 1'b0;
    gate_in = 1'b0; prot_cmp = 1'b0; rail_ov = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset latched", latched, 1'b0);
    chk("R1 reset gate_out", gate_out, 1'b0);

    gate_in = 1'b1;
    @(negedge clk);
    chk("R2 gate follows", gate_out, 1'b1);
    gate_in = 1'b0;
    @(negedge clk);
    chk("R2 gate low", gate_out, 1'b0);

    // R6: three events, a gap, three events: no latch
    for (int i = 0; i < 3; i++) run_cycle(18, 3);
    run_cycle(0, 0);
    for (int i = 0; i < 3; i++) run_cycle(18, 3);
    chk("R6 gap restarts count", latched, 1'b0);
    run_cycle(18, 3);
    chk("R5 fourth consecutive event", latched, 1'b1);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R2 gate forced off", gate_out, 1'b0);
    gate_in = 1'b0;

    release_latch();
    chk("R10 release clears", latched, 1'b0);

    // R10: count cleared by release
    for (int i = 0; i < 3; i++) run_cycle(18, 3);
    release_latch();
    for (int i = 0; i < 3; i++) run_cycle(18, 3);
    chk("R10 release clears count", latched, 1'b0);
    release_latch();

    // R7: highs while gate is on are ignored
    for (int i = 0; i < 5; i++) run_cycle(2, 8);
    chk("R7 on-time ignored", latched, 1'b0);

    // R3: highs only during blanking
    for (int i = 0; i < 5; i++) run_cycle(ON_LAST + 1, B + 1);
    chk("R3 blanking ignored", latched, 1'b0);

    // R4: short pulses
    for (int i = 0; i < 5; i++) run_cycle(20, M - 1);
    chk("R4 short pulse ignored", latched, 1'b0);
    release_latch();

    // R3 R4 R5 sweep of start position and width
    for (int s = ON_LAST + 1; s <= LAST_POS - 2; s++) begin
      for (int w = 1; w <= 5; w++) begin
        for (int c = 0; c < N; c++) run_cycle(s, w);
        chk($sformatf("R3 R4 R5 sweep s=%0d w=%0d", s, w), latched, qualifies(s, w));
        release_latch();
      end
    end

    // R8: persistence
    rail_hold(OVP - 1);
    rail_hold(OVP - 1);
    chk("R8 short overvoltage ignored", latched, 1'b0);
    rail_hold(OVP);
    chk("R8 overvoltage latches", latched, 1'b1);

    // R9: sticky after faults vanish
    for (int i = 0; i < 3; i++) run_cycle(0, 0);
    chk("R9 latch sticky", latched, 1'b1);
    gate_in = 1'b1;
    @(negedge clk);
    chk("R9 gate stays off", gate_out, 1'b0);
    gate_in = 1'b0;

    // R10: release wins over simultaneous fire
    release_latch();
    rail_ov = 1'b1;
    repeat (OVP - 1) @(negedge clk);
    hold_lost = 1'b1;
    @(negedge clk);
    hold_lost = 1'b0;
    rail_ov = 1'b0;
    @(negedge clk);
    chk("R10 release priority", latched, 1'b0);

    // R1: reset clears a latch
    rail_hold(OVP);
    chk("R8 relatch", latched, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset clears latch", latched, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule